// File: doc/BRIEF.md
# Dual-Rail Lookahead Adder/Subtractor

This block adds or subtracts two unsigned or two's-complement operands and reports when the answer has settled. Every carry is held as a pair of wires. One wire says "the carry is 1" and the other says "the carry is 0". Both low is the empty (spacer) state, and both high is never allowed. A carry has resolved once exactly one of its wires is high.

The operand bits form groups of `GROUP_W` bits. Inside a group the carry ripples from bit to bit. Between groups, a network of generate and propagate terms, one set for each rail, carries the result forward. The group carry registers advance once per clock, and a group that generates or kills its own carry resolves on the first step. Because of this, the completion flag rises after a number of cycles that depends on the data: it equals the longest run of fully-propagating groups, plus one. Operand B comes either straight from its input or from a per-bit logic stage that combines A and B. Subtraction inverts B and puts a 1 on the carry-in.

A caller pulses `start` while the block is idle and then waits for `done`. The result and `done` stay unchanged until the next accepted `start`.

Top module: `dr_addsub`

## Requirements
- R1: While reset is active and after it is released, `done`, `result` and `cout` are 0 until an operation completes.
- R2: With `sub`=0, the completed `{cout,result}` equals A + B' as an unsigned (WIDTH+1)-bit sum, where B' is the selected B operand.
- R3: With `sub`=1, the completed `result` equals A − B' modulo 2^WIDTH. `cout` is the carry out of A + ~B' + 1, so it is 1 exactly when A ≥ B' unsigned.
- R4: With `bsel`=1, B' is the bitwise function of A and B selected by `lfn`: 0 = AND, 1 = OR, 2 = XOR, 3 = XNOR. With `bsel`=0, B' = B.
- R5: Number the groups from the LSB. Group g counts as propagating when every bit of A XOR (effective B) in it is 1. Its step is 1 if g = 0 or the group does not propagate, and otherwise one more than the step of group g−1. Let T be the largest step. Then `done` rises exactly T+1 clock edges after the edge that accepts `start`.
- R6: A `start` that arrives while an operation is in flight is ignored. The in-flight operation completes with its own operands and timing.
- R7: On the edge after an accepted `start`, every group carry register holds the spacer state (both rails 0).
- R8: No carry register ever has both rails at 1.
- R9: `done` is high only while every group carry and every in-group bit carry has exactly one rail high.
- R10: While `done` is high and `start` is low, `done`, `result` and `cout` hold their values.
- R11: An accepted `start` drops `done` on the same edge.
- R12: Once a group carry register has resolved, it equals the dual-rail carry that the group's own ripple chain produces at its MSB.
- R13: The carry-in is seeded on acceptance. For subtraction it is the 1-rail, for addition the 0-rail.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| sub | input | 1 | 1 = subtract, 0 = add |
| bsel | input | 1 | 1 = B operand from logic stage, 0 = raw B |
| lfn | input | 2 | Logic stage function: 0 AND, 1 OR, 2 XOR, 3 XNOR |
| a | input | WIDTH | Operand A |
| b | input | WIDTH | Operand B |
| result | output | WIDTH | Sum or difference, registered |
| cout | output | 1 | Carry out of the MSB (1-rail) |
| done | output | 1 | Completion flag |

## Verification
The hardest case to reach is a long chain of groups that all propagate, because only then does completion wait for the lookahead to walk the whole width. The bench forces it with A all ones and B zero for addition, and with equal operands for subtraction, since both make every A XOR B' bit 1. Random operands then give a mix of short and partial chains. The bench also issues a second `start` inside a busy window to show that the block ignores it. For every operation it predicts the completion cycle from the group-propagation rule and compares `done` on every clock.

// File: rtl/dr_pkg.sv
package dr_pkg;

  // Dual-rail carry: exactly one wire high means resolved.
  typedef struct packed {
    logic one;
    logic zero;
  } rail_t;

  localparam rail_t RAIL_NULL = 2'b00;
  localparam rail_t RAIL_ONE  = 2'b10;
  localparam rail_t RAIL_ZERO = 2'b01;

  typedef enum logic [1:0] {
    LF_AND  = 2'd0,
    LF_OR   = 2'd1,
    LF_XOR  = 2'd2,
    LF_XNOR = 2'd3
  } lfn_e;

  function automatic logic rail_valid(rail_t r);
    return r.one ^ r.zero;
  endfunction

endpackage

// File: rtl/dr_logic_stage.sv
module dr_logic_stage
  import dr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         bsel,
  input  logic [1:0]   fn,
  output logic [W-1:0] bsrc
);

  logic [W-1:0] fres;

  always_comb begin
    case (lfn_e'(fn))
      LF_AND:  fres = a & b;
      LF_OR:   fres = a | b;
      LF_XOR:  fres = a ^ b;
      default: fres = ~(a ^ b);
    endcase
  end

  assign bsrc = bsel ? fres : b;

endmodule

// File: rtl/dr_group.sv
module dr_group
  import dr_pkg::*;
#(
  parameter int GW = 4
) (
  input  logic [GW-1:0] a,
  input  logic [GW-1:0] bx,
  input  rail_t         cin,
  output logic [GW-1:0] sum,
  output logic          gen1,
  output logic          gen0,
  output logic          prop,
  output rail_t         cout,
  output logic          settled
);

  logic [GW-1:0] g1, g0, p, ok;
  logic [GW:0]   c1, c0, acc1, acc0;

  assign g1 = a & bx;
  assign g0 = ~a & ~bx;
  assign p  = a ^ bx;

  assign c1[0]   = cin.one;
  assign c0[0]   = cin.zero;
  assign acc1[0] = 1'b0;
  assign acc0[0] = 1'b0;

  for (genvar i = 0; i < GW; i++) begin : g_bit
    // ripple on both rails
    assign c1[i+1]   = g1[i] | (p[i] & c1[i]);
    assign c0[i+1]   = g0[i] | (p[i] & c0[i]);
    assign sum[i]    = p[i] ^ c1[i];
    assign ok[i]     = c1[i+1] ^ c0[i+1];
    // group terms independent of carry-in
    assign acc1[i+1] = g1[i] | (p[i] & acc1[i]);
    assign acc0[i+1] = g0[i] | (p[i] & acc0[i]);
  end

  assign gen1    = acc1[GW];
  assign gen0    = acc0[GW];
  assign prop    = &p;
  assign cout    = {c1[GW], c0[GW]};
  assign settled = &ok;

endmodule

// File: rtl/dr_gp_net.sv
module dr_gp_net
  import dr_pkg::*;
#(
  parameter int NG = 4
) (
  input  logic  [NG-1:0] gen1,
  input  logic  [NG-1:0] gen0,
  input  logic  [NG-1:0] prop,
  input  rail_t          seed,
  input  rail_t [NG-1:0] cur,
  output rail_t [NG-1:0] nxt
);

  always_comb begin
    rail_t ci;
    ci  = seed;
    nxt = '0;
    for (int g = 0; g < NG; g++) begin
      nxt[g].one  = gen1[g] | (prop[g] & ci.one);
      nxt[g].zero = gen0[g] | (prop[g] & ci.zero);
      ci = cur[g];
    end
  end

endmodule

// File: rtl/dr_addsub.sv
module dr_addsub
  import dr_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int GROUP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             sub,
  input  logic             bsel,
  input  logic [1:0]       lfn,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] result,
  output logic             cout,
  output logic             done
);

  localparam int NGRP = WIDTH / GROUP_W;

  logic              run_q;
  logic [WIDTH-1:0]  a_q, bx_q, bsrc, sum_w;
  rail_t             seed_q;
  rail_t [NGRP-1:0]  grail_q, grail_nx;
  logic  [NGRP-1:0]  gen1, gen0, prop, settled, resolved;
  rail_t             grp_cin [NGRP];
  rail_t             msb_c   [NGRP];
  logic              accept, complete, illegal;

  dr_logic_stage #(.W(WIDTH)) u_lstage (
    .a(a), .b(b), .bsel(bsel), .fn(lfn), .bsrc(bsrc)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    if (g == 0) begin : g_first
      assign grp_cin[g] = seed_q;
    end else begin : g_rest
      assign grp_cin[g] = grail_q[g-1];
    end

    dr_group #(.GW(GROUP_W)) u_group (
      .a      (a_q [g*GROUP_W +: GROUP_W]),
      .bx     (bx_q[g*GROUP_W +: GROUP_W]),
      .cin    (grp_cin[g]),
      .sum    (sum_w[g*GROUP_W +: GROUP_W]),
      .gen1   (gen1[g]),
      .gen0   (gen0[g]),
      .prop   (prop[g]),
      .cout   (msb_c[g]),
      .settled(settled[g])
    );
  end

  dr_gp_net #(.NG(NGRP)) u_net (
    .gen1(gen1), .gen0(gen0), .prop(prop),
    .seed(seed_q), .cur(grail_q), .nxt(grail_nx)
  );

  always_comb begin
    illegal = (seed_q.one & seed_q.zero);
    for (int g = 0; g < NGRP; g++) begin
      resolved[g] = rail_valid(grail_q[g]);
      illegal     = illegal | (grail_q[g].one & grail_q[g].zero);
    end
  end

  assign accept   = start & ~run_q;
  assign complete = (&resolved) & (&settled);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      a_q     <= '0;
      bx_q    <= '0;
      seed_q  <= RAIL_NULL;
      grail_q <= '0;
      result  <= '0;
      cout    <= 1'b0;
      done    <= 1'b0;
    end else if (accept) begin
      run_q   <= 1'b1;
      a_q     <= a;
      bx_q    <= bsrc ^ {WIDTH{sub}};
      seed_q  <= sub ? RAIL_ONE : RAIL_ZERO;
      grail_q <= '0;
      done    <= 1'b0;
    end else if (run_q) begin
      grail_q <= grail_nx;
      if (complete) begin
        run_q  <= 1'b0;
        result <= sum_w;
        cout   <= grail_q[NGRP-1].one;
        done   <= 1'b1;
      end
    end
  end

  // ---------------- assertions ----------------
  p_rails_legal_r8: assert property (@(posedge clk) disable iff (rst)
    !illegal);

  p_spacer_after_start_r7: assert property (@(posedge clk) disable iff (rst)
    accept |=> (grail_q == '0));

  p_seed_sub_r13: assert property (@(posedge clk) disable iff (rst)
    (accept && sub) |=> (seed_q == RAIL_ONE));

  p_seed_add_r13: assert property (@(posedge clk) disable iff (rst)
    (accept && !sub) |=> (seed_q == RAIL_ZERO));

  p_done_resolved_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> ((&resolved) && (&settled)));

  p_no_early_done_r9: assert property (@(posedge clk) disable iff (rst)
    (run_q && !complete) |=> !done);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(result) && $stable(cout)));

  p_busy_ignore_r6: assert property (@(posedge clk) disable iff (rst)
    (run_q && start) |=> ($stable(a_q) && $stable(bx_q)));

  p_done_drop_r11: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> !done);

  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    p_lookahead_match_r12: assert property (@(posedge clk) disable iff (rst)
      resolved[g] |-> (grail_q[g] == msb_c[g]));
  end

endmodule

// File: tb/dr_addsub_tb.sv
`timescale 1ns/1ps
module dr_addsub_tb;
  localparam int W  = 16;
  localparam int GW = 4;
  localparam int NG = W / GW;

  logic         clk = 1'b0, rst = 1'b1, start = 1'b0, sub = 1'b0, bsel = 1'b0;
  logic [1:0]   lfn = 2'd0;
  logic [W-1:0] a = '0, b = '0;
  logic [W-1:0] result;
  logic         cout, done;

  dr_addsub #(.WIDTH(W), .GROUP_W(GW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .sub(sub), .bsel(bsel), .lfn(lfn),
    .a(a), .b(b), .result(result), .cout(cout), .done(done)
  );

  always #2.5 clk = ~clk;

  int    n_cmp = 0, n_bad = 0;
  string tag = "R1";

  // behavioural reference state
  bit           m_busy = 1'b0, m_done = 1'b0;
  logic [W-1:0] m_res = '0, p_res = '0;
  logic         m_cout = 1'b0, p_cout = 1'b0;
  int           m_cnt = 0;
  string        m_tag = "R1";

  function automatic logic [W-1:0] bsrc_f(logic [W-1:0] x, logic [W-1:0] y,
                                          logic s, logic [1:0] f);
    if (!s) return y;
    case (f)
      2'd0:    return x & y;
      2'd1:    return x | y;
      2'd2:    return x ^ y;
      default: return ~(x ^ y);
    endcase
  endfunction

  function automatic int lat_f(logic [W-1:0] px);
    int t = 0, tm = 0;
    for (int g = 0; g < NG; g++) begin
      logic [GW-1:0] sl;
      sl = px[g*GW +: GW];
      t  = (g == 0 || !(&sl)) ? 1 : t + 1;
      if (t > tm) tm = t;
    end
    return tm;
  endfunction

  task automatic check(string req, logic [W:0] act, logic [W:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin : mdl
    logic [W-1:0] bx;
    logic [W:0]   s;
    if (rst) begin
      m_busy = 1'b0; m_done = 1'b0; m_res = '0; m_cout = 1'b0; m_cnt = 0;
    end else if (!m_busy && start) begin
      bx     = bsrc_f(a, b, bsel, lfn) ^ {W{sub}};
      s      = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, sub};
      p_res  = s[W-1:0];
      p_cout = s[W];
      m_cnt  = lat_f(a ^ bx) + 1;
      m_busy = 1'b1;
      m_done = 1'b0;
      m_tag  = tag;
    end else if (m_busy) begin
      m_cnt = m_cnt - 1;
      if (m_cnt == 0) begin
        m_busy = 1'b0; m_done = 1'b1; m_res = p_res; m_cout = p_cout;
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check({m_tag, " R5 R9 done"}, {{W{1'b0}}, done}, {{W{1'b0}}, m_done});
      if (m_done && done) check(m_tag, {cout, result}, {m_cout, m_res});
    end
  end

  task automatic op(logic [W-1:0] xa, logic [W-1:0] xb, logic xs,
                    logic xsel, logic [1:0] xf, string t);
    logic [W:0] held;
    @(negedge clk);
    a = xa; b = xb; sub = xs; bsel = xsel; lfn = xf; tag = t;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R11 done low after start", {{W{1'b0}}, done}, '0);
    while (m_busy) @(negedge clk);
    held = {cout, result};
    repeat (3) @(negedge clk);
    check("R10 hold", {cout, result}, held);
    check("R10 done held", {{W{1'b0}}, done}, {{W{1'b0}}, 1'b1});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R5 watchdog actual=hung expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {cout, result}, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle outputs", {cout, result}, '0);
    check("R1 idle done", {{W{1'b0}}, done}, '0);

    // full-length propagate chains
    op({W{1'b1}}, '0, 1'b0, 1'b0, 2'd0, "R2 R5 R12 all-ones+0");
    op('0, '0, 1'b1, 1'b0, 2'd0, "R3 R5 R13 zero-zero");
    op(16'h1234, 16'h1234, 1'b1, 1'b0, 2'd0, "R3 R5 equal-sub");
    // corner operands
    op('0, 16'h0001, 1'b1, 1'b0, 2'd0, "R3 R13 borrow");
    op(16'h8000, 16'h0001, 1'b1, 1'b0, 2'd0, "R3 max-neg");
    op(16'h7FFF, 16'h0001, 1'b0, 1'b0, 2'd0, "R2 overflow");
    op({W{1'b1}}, 16'h0001, 1'b0, 1'b0, 2'd0, "R2 R13 wrap");
    op({W{1'b1}}, {W{1'b1}}, 1'b0, 1'b0, 2'd0, "R2 R7 all-gen");
    op('0, '0, 1'b0, 1'b0, 2'd0, "R2 R8 all-kill");
    // logic stage feeding B
    op(16'hF0F0, 16'hFF00, 1'b0, 1'b1, 2'd0, "R4 and");
    op(16'hF0F0, 16'h0F0F, 1'b0, 1'b1, 2'd1, "R4 or");
    op(16'hAAAA, 16'h5555, 1'b1, 1'b1, 2'd2, "R4 xor");
    op(16'h1357, 16'h1357, 1'b0, 1'b1, 2'd3, "R4 xnor");

    // start during busy is ignored
    @(negedge clk);
    a = {W{1'b1}}; b = '0; sub = 1'b0; bsel = 1'b0; tag = "R6 busy-start";
    start = 1'b1;
    @(negedge clk);
    a = 16'h0003; b = 16'h0004; sub = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
    @(negedge clk);
    check("R6 first op kept", {cout, result}, {1'b0, {W{1'b1}}});

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] ra, rb;
      logic         rs, rsel;
      logic [1:0]   rf;
      ra   = W'($urandom);
      rb   = (i % 5 == 0) ? ~ra : W'($urandom);
      rs   = 1'($urandom);
      rsel = (i % 3 == 0);
      rf   = 2'($urandom);
      op(ra, rb, rs, rsel, rf, rsel ? "R4 R7 random" : (rs ? "R3 R12 random" : "R2 R8 random"));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule